// File: doc/BRIEF.md
# Quadrature Position Decoder with Byte-Preset Counter

This block watches the two phase inputs of one incremental shaft encoder and keeps a 16-bit signed-agnostic position count. Every rising or falling edge on either phase moves the count by exactly one, giving four counts per full quadrature cycle. The direction comes from the phase order. A polarity control bit decides which phase order counts up, and an enable bit starts or freezes counting.

Software sees three byte-wide registers through a simple register port: a control byte, the low count byte and the high count byte. The count can be read at any time. Reading the low byte captures the high byte, so a low-then-high read sequence returns one coherent 16-bit value. Writing either count byte presets that half of the counter, which is meant to be done while counting is disabled.

A single-cycle event output goes high each time the count increments, for use by an interrupt controller. Decrements give no event.

Top module: `qdec_top`

## Requirements
- R1: After reset the count is 0x0000, the control byte reads 0x02 (enable bit 0 clear, polarity bit 1 set) and `count_inc` is low.
- R2: With counting enabled, each single-phase edge on A or B changes the count by exactly one, so one full quadrature cycle moves it by four.
- R3: With polarity 1, phase A leading B (state {A,B} stepping 00, 10, 11, 01) counts up, and B leading A counts down.
- R4: With polarity 0, A leading B counts down and B leading A counts up.
- R5: With the enable bit (control bit 0) at 0, the count holds its value whatever the phases do.
- R6: Register offset 0 is control (bit 0 enable, bit 1 polarity, other bits read 0). Writing offset 1 loads count bits 7:0 and writing offset 2 loads count bits 15:8, so any 16-bit value can be preset. Offset 3 reads 0 and ignores writes.
- R7: A read of offset 1 returns the live low byte and captures the high byte. A read of offset 2 returns the byte captured by the most recent low-byte read.
- R8: The count wraps modulo 2^16: up from 0xFFFF gives 0x0000, and down from 0x0000 gives 0xFFFF.
- R9: A sample in which both phases changed at once is an illegal transition and leaves the count unchanged.
- R10: `count_inc` is high for exactly one cycle per increment, in the cycle the incremented value first appears, and never for a decrement.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_a | input | 1 | Encoder phase A, asynchronous |
| enc_b | input | 1 | Encoder phase B, asynchronous |
| reg_addr | input | 2 | Register offset |
| reg_wr | input | 1 | Write strobe, one cycle |
| reg_rd | input | 1 | Read strobe, one cycle |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the addressed register, combinational |
| count_inc | output | 1 | One-cycle pulse on each count increment |

## Verification
The assertions assume that the phases reach the decoder as clean two-bit Gray steps, with at most one phase changing per sample unless an illegal step is meant. They also assume that a preset write and a phase step never fall in the same cycle when step size is being checked. The bench changes one phase at a time on the falling clock edge and waits well beyond the synchronizer delay before the next change. It flips both phases in one drive only in the illegal-step scenario, and it presets only while counting is disabled.

// File: rtl/qdec_pkg.sv
package qdec_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] OFS_LO   = 2'd1;
    localparam logic [ADDR_W-1:0] OFS_HI   = 2'd2;

    typedef enum logic [1:0] {
        MV_NONE  = 2'd0,
        MV_AHEAD = 2'd1,
        MV_BHEAD = 2'd2,
        MV_BAD   = 2'd3
    } move_e;

    typedef struct packed {
        logic up;
        logic down;
    } step_t;

    typedef struct packed {
        logic polarity;
        logic enable;
    } ctrl_t;

    // Next phase state {A,B} when A leads B: 00 -> 10 -> 11 -> 01 -> 00
    function automatic logic [1:0] a_lead_next(input logic [1:0] s);
        case (s)
            2'b00:   a_lead_next = 2'b10;
            2'b10:   a_lead_next = 2'b11;
            2'b11:   a_lead_next = 2'b01;
            default: a_lead_next = 2'b00;
        endcase
    endfunction

    function automatic move_e classify(input logic [1:0] prev, input logic [1:0] cur);
        if (prev == cur)
            classify = MV_NONE;
        else if ((prev ^ cur) == 2'b11)
            classify = MV_BAD;
        else if (cur == a_lead_next(prev))
            classify = MV_AHEAD;
        else
            classify = MV_BHEAD;
    endfunction

endpackage

// File: rtl/qdec_sync.sv
module qdec_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] pipe [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) pipe[g] <= '0;
                else     pipe[g] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) pipe[g] <= '0;
                else     pipe[g] <= pipe[g-1];
            end
        end
    end

    assign dout = pipe[STAGES-1];
endmodule

// File: rtl/qdec_phase.sv
module qdec_phase
    import qdec_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] cur,
    input  ctrl_t      ctrl,
    output step_t      step
);
    logic [1:0] prev;
    move_e      mv;

    always_ff @(posedge clk) begin
        if (rst) prev <= 2'b00;
        else     prev <= cur;
    end

    always_comb begin
        mv        = classify(prev, cur);
        step.up   = 1'b0;
        step.down = 1'b0;
        if (ctrl.enable) begin
            if (mv == MV_AHEAD) begin
                step.up   = ctrl.polarity;
                step.down = !ctrl.polarity;
            end else if (mv == MV_BHEAD) begin
                step.up   = !ctrl.polarity;
                step.down = ctrl.polarity;
            end
        end
    end

    AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (rst)
        $onehot0({step.up, step.down})); // R3
    AST_SINGLE_PHASE: assert property (@(posedge clk) disable iff (rst)
        (step.up || step.down) |-> ($countones(prev ^ cur) == 1)); // R9
endmodule

// File: rtl/qdec_counter.sv
module qdec_counter
    import qdec_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  step_t             step,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [CNT_W-1:0]  count,
    output logic              inc_evt
);
    localparam int HI_W = CNT_W - BYTE_W;

    logic preset;
    assign preset = wr_lo || wr_hi;

    always_ff @(posedge clk) begin
        if (rst) begin
            count   <= '0;
            inc_evt <= 1'b0;
        end else begin
            inc_evt <= step.up && !preset;
            if (preset) begin
                if (wr_lo) count[BYTE_W-1:0]     <= wr_data;
                if (wr_hi) count[CNT_W-1:BYTE_W] <= wr_data[HI_W-1:0];
            end else if (step.up) begin
                count <= count + 1'b1;
            end else if (step.down) begin
                count <= count - 1'b1;
            end
        end
    end

    AST_STEP_UP: assert property (@(posedge clk) disable iff (rst)
        (step.up && !preset) |=> (count == $past(count) + 1'b1)); // R2
    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (rst)
        (step.down && !preset) |=> (count == $past(count) - 1'b1)); // R2
    AST_EVT_MEANS_UP: assert property (@(posedge clk) disable iff (rst)
        inc_evt |-> (count == $past(count) + 1'b1)); // R10
endmodule

// File: rtl/qdec_top.sv
module qdec_top
    import qdec_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int SYNC_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enc_a,
    input  logic              enc_b,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    output logic              count_inc
);
    localparam int HI_W = CNT_W - BYTE_W;

    ctrl_t            ctrl;
    logic [1:0]       phases;
    step_t            step;
    logic [CNT_W-1:0] count;
    logic [HI_W-1:0]  hi_hold;
    logic             wr_lo, wr_hi;

    assign wr_lo = reg_wr && (reg_addr == OFS_LO);
    assign wr_hi = reg_wr && (reg_addr == OFS_HI);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl.enable   <= 1'b0;
            ctrl.polarity <= 1'b1;
        end else if (reg_wr && reg_addr == OFS_CTRL) begin
            ctrl.enable   <= reg_wdata[0];
            ctrl.polarity <= reg_wdata[1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                               hi_hold <= '0;
        else if (reg_rd && reg_addr == OFS_LO) hi_hold <= count[CNT_W-1:BYTE_W];
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_CTRL: reg_rdata = {{(BYTE_W-2){1'b0}}, ctrl.polarity, ctrl.enable};
            OFS_LO:   reg_rdata = count[BYTE_W-1:0];
            OFS_HI:   reg_rdata = BYTE_W'(hi_hold);
            default:  reg_rdata = '0;
        endcase
    end

    qdec_sync #(.W(2), .STAGES(SYNC_DEPTH)) u_sync (
        .clk (clk),
        .rst (rst),
        .din ({enc_a, enc_b}),
        .dout(phases)
    );

    qdec_phase u_phase (
        .clk (clk),
        .rst (rst),
        .cur (phases),
        .ctrl(ctrl),
        .step(step)
    );

    qdec_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .step   (step),
        .wr_lo  (wr_lo),
        .wr_hi  (wr_hi),
        .wr_data(reg_wdata),
        .count  (count),
        .inc_evt(count_inc)
    );

    AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.enable && !wr_lo && !wr_hi) |=> $stable(count)); // R5
    AST_HI_FROM_HOLD: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == OFS_LO) |=> (hi_hold == $past(count[CNT_W-1:BYTE_W]))); // R7
endmodule

// File: tb/sim_qdec_top.sv
module sim_qdec_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       enc_a = 1'b0, enc_b = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       count_inc;

    int checks = 0, fails = 0, pulses = 0;
    logic [1:0] st = 2'b00;

    always #4 clk = ~clk;

    qdec_top u0 (
        .clk(clk), .rst(rst), .enc_a(enc_a), .enc_b(enc_b),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .count_inc(count_inc)
    );

    always @(negedge clk) if (!rst && count_inc) pulses++;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic rd_count(output int v);
        logic [7:0] lo, hi;
        rd(2'd1, lo);
        rd(2'd2, hi);
        v = {hi, lo};
    endtask

    function automatic logic [1:0] fwd(input logic [1:0] s);
        case (s)
            2'b00: return 2'b10;
            2'b10: return 2'b11;
            2'b11: return 2'b01;
            default: return 2'b00;
        endcase
    endfunction

    function automatic logic [1:0] rev(input logic [1:0] s);
        case (s)
            2'b00: return 2'b01;
            2'b01: return 2'b11;
            2'b11: return 2'b10;
            default: return 2'b00;
        endcase
    endfunction

    task automatic drive(input logic [1:0] s);
        @(negedge clk);
        st = s; enc_a = s[1]; enc_b = s[0];
        repeat (5) @(negedge clk);
    endtask

    task automatic a_lead(input int n);
        for (int i = 0; i < n; i++) drive(fwd(st));
    endtask

    task automatic b_lead(input int n);
        for (int i = 0; i < n; i++) drive(rev(st));
    endtask

    task automatic t_reset;
        logic [7:0] c; int v;
        rd(2'd0, c);
        check("R1 ctrl", c, 8'h02);
        rd_count(v);
        check("R1 count", v, 0);
        check("R1 count_inc", count_inc, 0);
    endtask

    task automatic t_pol1;
        int v, p0;
        wr(2'd0, 8'h03);
        p0 = pulses;
        a_lead(8);
        rd_count(v);
        check("R2 R3 up 8 edges", v, 8);
        check("R10 one pulse per increment", pulses - p0, 8);
        p0 = pulses;
        b_lead(3);
        rd_count(v);
        check("R3 down 3 edges", v, 5);
        check("R10 no pulse on decrement", pulses - p0, 0);
    endtask

    task automatic t_pol0;
        int v;
        wr(2'd0, 8'h01);
        a_lead(2);
        rd_count(v);
        check("R4 A lead counts down", v, 3);
        b_lead(4);
        rd_count(v);
        check("R4 B lead counts up", v, 7);
    endtask

    task automatic t_disabled;
        int v;
        wr(2'd0, 8'h02);
        a_lead(4);
        b_lead(1);
        rd_count(v);
        check("R5 hold while disabled", v, 7);
    endtask

    task automatic t_preset;
        int v; logic [7:0] c;
        wr(2'd1, 8'h34);
        wr(2'd2, 8'h12);
        rd_count(v);
        check("R6 preset", v, 16'h1234);
        wr(2'd3, 8'hFF);
        rd(2'd3, c);
        check("R6 offset 3 reads 0", c, 0);
        rd_count(v);
        check("R6 offset 3 write ignored", v, 16'h1234);
    endtask

    task automatic t_wrap;
        int v;
        wr(2'd1, 8'hFF);
        wr(2'd2, 8'hFF);
        wr(2'd0, 8'h03);
        a_lead(1);
        rd_count(v);
        check("R8 wrap up", v, 0);
        b_lead(1);
        rd_count(v);
        check("R8 wrap down", v, 16'hFFFF);
    endtask

    task automatic t_illegal;
        int v;
        drive(~st);
        rd_count(v);
        check("R9 double change ignored", v, 16'hFFFF);
        a_lead(1);
        rd_count(v);
        check("R9 counting resumes", v, 0);
    endtask

    task automatic t_latch;
        logic [7:0] lo, hi;
        wr(2'd0, 8'h02);
        wr(2'd1, 8'hFF);
        wr(2'd2, 8'h00);
        wr(2'd0, 8'h03);
        rd(2'd1, lo);
        check("R7 low byte", lo, 8'hFF);
        a_lead(1);
        rd(2'd2, hi);
        check("R7 high from capture", hi, 8'h00);
        rd(2'd1, lo);
        rd(2'd2, hi);
        check("R7 fresh pair", {hi, lo}, 16'h0100);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst = 1'b0;
                t_reset();
                t_pol1();
                t_pol0();
                t_disabled();
                t_preset();
                t_wrap();
                t_illegal();
                t_latch();
            end
            begin
                repeat (20000) @(negedge clk);
                checks++; fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule